// File: doc/BRIEF.md
# Transaction Pad Stripper

This block sits on a header-plus-data bus in which every transaction is announced by one header beat. The header carries an identifier, a length (beat count minus one) and a pad-count field giving how many trailing bytes of the payload are filler. The data beats follow on a separate ready/valid channel. The stripper undoes the work of an earlier padding stage. For each transaction it reads the pad count and works out how many whole trailing beats are pure filler. It forwards only the beats that come before them and lowers the header length to match.

The trim works at whole-beat granularity. Bytes of filler that do not fill a complete beat stay inside the last forwarded beat. Their count is reported on a separate tail-byte output of the header, and the header's pad-count field leaves the block cleared. The block handles one transaction at a time: a new header is refused until every input beat of the current transaction has been taken in, including the dropped ones. Both output channels are registered. Input and output share the same data width, beat limit and identifier range.

Top module: `pad_stripper`

## Requirements
- R1: After reset both output valids are low, `hdr_in_ready` is high and `dat_in_ready` is low.
- R2: `dat_in_ready` is low while no transaction is open. It is high in the cycle after a header is accepted, provided the data output stage is free.
- R3: With B bytes per beat, the output length equals the input length minus floor(pad/B). When floor(pad/B) is at least the input length, the output length saturates at 0, so one beat is always kept.
- R4: The output pad-count field is always 0. `hdr_out_tail` equals pad mod B, the filler bytes left inside the last kept beat.
- R5: The output header carries the input header's identifier unchanged.
- R6: The first (output length + 1) input beats are forwarded in order with data and identifier unchanged. The remaining input beats are accepted and never appear on the output.
- R7: `hdr_in_ready` stays low from the cycle after a header is accepted until the last input beat of that transaction has been consumed. It returns high in the cycle after that, provided the header output stage is free.
- R8: While an output valid is high and its ready is low, that valid stays high and its payload stays stable. No beat is lost or duplicated under back-pressure.
- R9: With a pad count of 0, the transaction passes through with its length and every beat intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_in_valid | input | 1 | Input header valid |
| hdr_in_ready | output | 1 | Input header ready |
| hdr_in_len | input | LEN_W | Input beat count minus one |
| hdr_in_id | input | ID_W | Input transaction identifier |
| hdr_in_pad | input | PAD_W | Trailing filler byte count |
| dat_in_valid | input | 1 | Input data valid |
| dat_in_ready | output | 1 | Input data ready |
| dat_in_data | input | DATA_W | Input data beat |
| dat_in_id | input | ID_W | Input data identifier |
| hdr_out_valid | output | 1 | Output header valid |
| hdr_out_ready | input | 1 | Output header ready |
| hdr_out_len | output | LEN_W | Output beat count minus one |
| hdr_out_id | output | ID_W | Output transaction identifier |
| hdr_out_pad | output | PAD_W | Output filler count, always 0 |
| hdr_out_tail | output | TAIL_W | Filler bytes remaining in last kept beat |
| dat_out_valid | output | 1 | Output data valid |
| dat_out_ready | input | 1 | Output data ready |
| dat_out_data | output | DATA_W | Output data beat |
| dat_out_id | output | ID_W | Output data identifier |

## Verification
The bench builds the block with a 32-bit data path (4 bytes per beat), at most 8 beats per transaction, 4 identifiers and a 6-bit pad count. With these values a pad count can cover more whole beats than a transaction holds, so the saturation corner is reachable. Pad counts that are and are not multiples of the beat size both occur, and so does a transaction at the full 8-beat length. The small beat size also means a few pad values cover zero, one, several and all-but-one dropped beats. Short ready patterns on both outputs then exercise back-pressure during both the kept and the dropped part of a transaction.

// File: rtl/pad_strip_pkg.sv
package pad_strip_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BODY = 1'b1
  } strip_state_e;

endpackage

// File: rtl/pad_strip_oreg.sv
module pad_strip_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      dat_q <= in_data;
    end
  end

  // R8: a stalled output holds its valid and payload
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/pad_strip_calc.sv
module pad_strip_calc #(
  parameter int LEN_W  = 3,
  parameter int PAD_W  = 6,
  parameter int BYTES  = 4,
  parameter int TAIL_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic [LEN_W-1:0]  in_len,
  input  logic [PAD_W-1:0]  in_pad,
  output logic [LEN_W-1:0]  out_len,
  output logic [CNT_W-1:0]  keep_beats,
  output logic [TAIL_W-1:0] tail
);

  localparam int SHIFT = $clog2(BYTES);
  localparam int CW    = ((PAD_W > LEN_W) ? PAD_W : LEN_W) + 1;

  logic [CW-1:0] drop_all;
  logic [CW-1:0] len_x;
  logic [CW-1:0] diff;
  logic          sat;

  always_comb begin
    drop_all   = CW'(in_pad) >> SHIFT;
    len_x      = CW'(in_len);
    sat        = (drop_all >= len_x);
    diff       = len_x - drop_all;
    out_len    = sat ? '0 : LEN_W'(diff);
    keep_beats = CNT_W'(out_len) + CNT_W'(1);
    tail       = TAIL_W'(in_pad % PAD_W'(BYTES));
  end

  // R3: trimming never lengthens a transaction
  always_comb begin
    a_r3_len_shrinks: assert (out_len <= in_len);
  end

endmodule

// File: rtl/pad_strip_ctrl.sv
module pad_strip_ctrl
  import pad_strip_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_in_valid,
  input  logic             h_stage_ready,
  input  logic [CNT_W-1:0] keep_beats,
  input  logic [CNT_W-1:0] last_idx,
  output logic             hdr_in_ready,
  input  logic             dat_in_valid,
  input  logic             d_stage_ready,
  output logic             dat_in_ready,
  output logic             fwd_valid
);

  strip_state_e     state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] keep_q;
  logic [CNT_W-1:0] last_q;
  logic             in_keep;
  logic             hdr_fire;
  logic             dat_fire;

  always_comb begin
    in_keep      = (idx_q < keep_q);
    hdr_in_ready = (state_q == ST_IDLE) && h_stage_ready;
    dat_in_ready = (state_q == ST_BODY) && (in_keep ? d_stage_ready : 1'b1);
    fwd_valid    = (state_q == ST_BODY) && dat_in_valid && in_keep;
    hdr_fire     = hdr_in_valid && hdr_in_ready;
    dat_fire     = dat_in_valid && dat_in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      keep_q  <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (hdr_fire) begin
            state_q <= ST_BODY;
            idx_q   <= '0;
            keep_q  <= keep_beats;
            last_q  <= last_idx;
          end
        end
        default: begin
          if (dat_fire) begin
            idx_q <= idx_q + CNT_W'(1);
            if (idx_q == last_q) begin
              state_q <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R7: an accepted header blocks the header channel next cycle
  a_r7_hdr_blocked: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |=> !hdr_in_ready);

  // R7: a non-final beat keeps the header channel blocked
  a_r7_hold_till_last: assert property (@(posedge clk) disable iff (rst)
    (dat_fire && (idx_q != last_q)) |=> !hdr_in_ready);

  // R6: beat index stays within the announced length
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BODY) |-> (idx_q <= last_q));

  // R6: kept beats never exceed the input beat count
  a_r6_keep_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BODY) |-> (keep_q <= last_q + CNT_W'(1)) && (keep_q != '0));

  // R2: no data is accepted while no transaction is open
  a_r2_idle_no_data: assert property (@(posedge clk) disable iff (rst)
    hdr_in_ready |-> !dat_in_ready);

endmodule

// File: rtl/pad_stripper.sv
module pad_stripper #(
  parameter int DATA_W       = 64,
  parameter int MAX_BEATS    = 16,
  parameter int MAX_INFLIGHT = 4,
  parameter int PAD_W        = 8,
  parameter int LEN_W        = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  parameter int ID_W         = (MAX_INFLIGHT > 1) ? $clog2(MAX_INFLIGHT) : 1,
  parameter int TAIL_W       = ($clog2(DATA_W / 8) > 0) ? $clog2(DATA_W / 8) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_in_valid,
  output logic              hdr_in_ready,
  input  logic [LEN_W-1:0]  hdr_in_len,
  input  logic [ID_W-1:0]   hdr_in_id,
  input  logic [PAD_W-1:0]  hdr_in_pad,
  input  logic              dat_in_valid,
  output logic              dat_in_ready,
  input  logic [DATA_W-1:0] dat_in_data,
  input  logic [ID_W-1:0]   dat_in_id,
  output logic              hdr_out_valid,
  input  logic              hdr_out_ready,
  output logic [LEN_W-1:0]  hdr_out_len,
  output logic [ID_W-1:0]   hdr_out_id,
  output logic [PAD_W-1:0]  hdr_out_pad,
  output logic [TAIL_W-1:0] hdr_out_tail,
  output logic              dat_out_valid,
  input  logic              dat_out_ready,
  output logic [DATA_W-1:0] dat_out_data,
  output logic [ID_W-1:0]   dat_out_id
);

  localparam int BYTES = DATA_W / 8;
  localparam int CNT_W = LEN_W + 1;
  localparam int HW    = ID_W + LEN_W + PAD_W + TAIL_W;
  localparam int DW    = ID_W + DATA_W;

  logic [LEN_W-1:0]  trim_len;
  logic [CNT_W-1:0]  keep_beats;
  logic [TAIL_W-1:0] trim_tail;
  logic              h_stage_ready;
  logic              d_stage_ready;
  logic              fwd_valid;
  logic              hdr_load;
  logic [HW-1:0]     hdr_pay_in;
  logic [HW-1:0]     hdr_pay_out;
  logic [DW-1:0]     dat_pay_out;

  pad_strip_calc #(
    .LEN_W (LEN_W),
    .PAD_W (PAD_W),
    .BYTES (BYTES),
    .TAIL_W(TAIL_W),
    .CNT_W (CNT_W)
  ) u_calc (
    .in_len    (hdr_in_len),
    .in_pad    (hdr_in_pad),
    .out_len   (trim_len),
    .keep_beats(keep_beats),
    .tail      (trim_tail)
  );

  pad_strip_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hdr_in_valid (hdr_in_valid),
    .h_stage_ready(h_stage_ready),
    .keep_beats   (keep_beats),
    .last_idx     ({1'b0, hdr_in_len}),
    .hdr_in_ready (hdr_in_ready),
    .dat_in_valid (dat_in_valid),
    .d_stage_ready(d_stage_ready),
    .dat_in_ready (dat_in_ready),
    .fwd_valid    (fwd_valid)
  );

  assign hdr_load   = hdr_in_valid && hdr_in_ready;
  assign hdr_pay_in = {hdr_in_id, trim_len, {PAD_W{1'b0}}, trim_tail};

  pad_strip_oreg #(
    .W(HW)
  ) u_hdr_reg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (hdr_load),
    .in_ready (h_stage_ready),
    .in_data  (hdr_pay_in),
    .out_valid(hdr_out_valid),
    .out_ready(hdr_out_ready),
    .out_data (hdr_pay_out)
  );

  pad_strip_oreg #(
    .W(DW)
  ) u_dat_reg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (fwd_valid),
    .in_ready (d_stage_ready),
    .in_data  ({dat_in_id, dat_in_data}),
    .out_valid(dat_out_valid),
    .out_ready(dat_out_ready),
    .out_data (dat_pay_out)
  );

  assign {hdr_out_id, hdr_out_len, hdr_out_pad, hdr_out_tail} = hdr_pay_out;
  assign {dat_out_id, dat_out_data} = dat_pay_out;

  // R4: the registered header never carries a nonzero pad count
  a_r4_pad_cleared: assert property (@(posedge clk) disable iff (rst)
    hdr_out_valid |-> (hdr_out_pad == '0));

  // R6: a forwarded beat appears on the output the next cycle
  a_r6_fwd_visible: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && dat_in_ready) |=> dat_out_valid);

endmodule

// File: tb/pad_stripper_test.sv
module pad_stripper_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int MAX_BEATS = 8;
  localparam int MAX_INFLIGHT = 4;
  localparam int PAD_W = 6;
  localparam int LEN_W = 3;
  localparam int ID_W = 2;
  localparam int TAIL_W = 2;
  localparam int BYTES = 4;
  localparam int HW = ID_W + LEN_W + PAD_W + TAIL_W;
  localparam int DW = ID_W + DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_in_valid = 1'b0;
  logic hdr_in_ready;
  logic [LEN_W-1:0] hdr_in_len = '0;
  logic [ID_W-1:0] hdr_in_id = '0;
  logic [PAD_W-1:0] hdr_in_pad = '0;
  logic dat_in_valid = 1'b0;
  logic dat_in_ready;
  logic [DATA_W-1:0] dat_in_data = '0;
  logic [ID_W-1:0] dat_in_id = '0;
  logic hdr_out_valid;
  logic hdr_out_ready = 1'b1;
  logic [LEN_W-1:0] hdr_out_len;
  logic [ID_W-1:0] hdr_out_id;
  logic [PAD_W-1:0] hdr_out_pad;
  logic [TAIL_W-1:0] hdr_out_tail;
  logic dat_out_valid;
  logic dat_out_ready = 1'b1;
  logic [DATA_W-1:0] dat_out_data;
  logic [ID_W-1:0] dat_out_id;

  int checks = 0;
  int fails = 0;
  logic bp = 1'b0;
  int cyc = 0;
  string tag = "R1";

  logic [HW-1:0] eh_q[$];
  logic [DW-1:0] ed_q[$];

  pad_stripper #(
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .MAX_INFLIGHT(MAX_INFLIGHT), .PAD_W(PAD_W)
  ) uut (
    .clk(clk), .rst(rst),
    .hdr_in_valid(hdr_in_valid), .hdr_in_ready(hdr_in_ready), .hdr_in_len(hdr_in_len),
    .hdr_in_id(hdr_in_id), .hdr_in_pad(hdr_in_pad),
    .dat_in_valid(dat_in_valid), .dat_in_ready(dat_in_ready), .dat_in_data(dat_in_data),
    .dat_in_id(dat_in_id),
    .hdr_out_valid(hdr_out_valid), .hdr_out_ready(hdr_out_ready), .hdr_out_len(hdr_out_len),
    .hdr_out_id(hdr_out_id), .hdr_out_pad(hdr_out_pad), .hdr_out_tail(hdr_out_tail),
    .dat_out_valid(dat_out_valid), .dat_out_ready(dat_out_ready), .dat_out_data(dat_out_data),
    .dat_out_id(dat_out_id)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ready drivers for the two outputs, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    hdr_out_ready <= bp ? (cyc % 3 != 0) : 1'b1;
    dat_out_ready <= bp ? ((cyc % 5) < 2) : 1'b1;
  end

  // output monitor: samples on the falling edge
  logic hstall_prev = 1'b0;
  logic dstall_prev = 1'b0;
  logic [HW-1:0] hprev = '0;
  logic [DW-1:0] dprev = '0;

  always @(negedge clk) begin
    logic [HW-1:0] hcur;
    logic [DW-1:0] dcur;
    logic [HW-1:0] he;
    logic [DW-1:0] de;
    if (!rst) begin
      hcur = {hdr_out_id, hdr_out_len, hdr_out_pad, hdr_out_tail};
      dcur = {dat_out_id, dat_out_data};
      if (hstall_prev) chk(hdr_out_valid && (hcur == hprev), "R8 header hold", 64'(hcur), 64'(hprev));
      if (dstall_prev) chk(dat_out_valid && (dcur == dprev), "R8 data hold", 64'(dcur), 64'(dprev));
      if (hdr_out_valid && hdr_out_ready) begin
        if (eh_q.size() == 0) begin
          chk(1'b0, {tag, " unexpected header (R3 R5)"}, 64'(hcur), 64'(0));
        end else begin
          he = eh_q.pop_front();
          chk(hcur == he, {tag, " header len/id/pad/tail (R3 R4 R5)"}, 64'(hcur), 64'(he));
        end
      end
      if (dat_out_valid && dat_out_ready) begin
        if (ed_q.size() == 0) begin
          chk(1'b0, {tag, " unexpected beat (R6)"}, 64'(dcur), 64'(0));
        end else begin
          de = ed_q.pop_front();
          chk(dcur == de, {tag, " forwarded beat (R6)"}, 64'(dcur), 64'(de));
        end
      end
      hstall_prev = hdr_out_valid && !hdr_out_ready;
      dstall_prev = dat_out_valid && !dat_out_ready;
      hprev = hcur;
      dprev = dcur;
    end
  end

  function automatic int exp_len(input int len, input int pad);
    int d;
    d = pad / BYTES;
    if (d >= len) return 0;
    return len - d;
  endfunction

  task automatic send_txn(input int id, input int len, input int pad, input logic [DATA_W-1:0] base);
    int ol;
    logic r;
    ol = exp_len(len, pad);
    eh_q.push_back({ID_W'(id), LEN_W'(ol), PAD_W'(0), TAIL_W'(pad % BYTES)});
    for (int i = 0; i <= ol; i++) ed_q.push_back({ID_W'(id), base + DATA_W'(i)});
    @(posedge clk); #1;
    hdr_in_valid = 1'b1;
    hdr_in_len = LEN_W'(len);
    hdr_in_id = ID_W'(id);
    hdr_in_pad = PAD_W'(pad);
    do begin
      @(negedge clk);
      r = hdr_in_ready;
      chk(dat_in_ready == 1'b0, "R2 idle data ready", 64'(dat_in_ready), 64'(0));
      @(posedge clk); #1;
    end while (!r);
    hdr_in_valid = 1'b0;
    for (int b = 0; b <= len; b++) begin
      dat_in_valid = 1'b1;
      dat_in_data = base + DATA_W'(b);
      dat_in_id = ID_W'(id);
      do begin
        @(negedge clk);
        r = dat_in_ready;
        if (b == 0 && !bp) chk(r == 1'b1, "R2 data ready after header", 64'(r), 64'(1));
        if (b > ol) chk(r == 1'b1, "R6 dropped beat consumed", 64'(r), 64'(1));
        chk(hdr_in_ready == 1'b0, "R7 header blocked", 64'(hdr_in_ready), 64'(0));
        @(posedge clk); #1;
      end while (!r);
    end
    dat_in_valid = 1'b0;
    if (!bp) begin
      @(negedge clk);
      chk(hdr_in_ready == 1'b1, "R7 header reopened", 64'(hdr_in_ready), 64'(1));
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (eh_q.size() == 0 && ed_q.size() == 0) break;
    end
    @(negedge clk);
    chk(eh_q.size() == 0 && ed_q.size() == 0, {tag, " all outputs delivered (R6)"},
        64'(eh_q.size() + ed_q.size()), 64'(0));
  endtask

  task automatic t_reset();
    tag = "R1";
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(hdr_out_valid == 1'b0, "R1 hdr_out_valid", 64'(hdr_out_valid), 64'(0));
    chk(dat_out_valid == 1'b0, "R1 dat_out_valid", 64'(dat_out_valid), 64'(0));
    chk(hdr_in_ready == 1'b1, "R1 hdr_in_ready", 64'(hdr_in_ready), 64'(1));
    chk(dat_in_ready == 1'b0, "R1 dat_in_ready", 64'(dat_in_ready), 64'(0));
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic t_passthrough();
    tag = "R9";
    send_txn(1, 3, 0, 32'h1000_0000);
    drain();
  endtask

  task automatic t_whole_beats();
    tag = "R3";
    send_txn(2, 5, 8, 32'h2000_0000);
    drain();
    send_txn(3, 7, 28, 32'h2100_0000);
    drain();
  endtask

  task automatic t_partial();
    tag = "R4";
    send_txn(3, 4, 6, 32'h3000_0000);
    drain();
    send_txn(0, 0, 3, 32'h3100_0000);
    drain();
  endtask

  task automatic t_saturate();
    tag = "R3 saturate";
    send_txn(0, 2, 20, 32'h4000_0000);
    drain();
    send_txn(2, 1, 63, 32'h4100_0000);
    drain();
  endtask

  task automatic t_id_carry();
    tag = "R5";
    for (int k = 0; k < MAX_INFLIGHT; k++) begin
      send_txn(k, 1 + k, 4, 32'h5000_0000 + 32'(k << 8));
    end
    drain();
  endtask

  task automatic t_backpressure();
    tag = "R8";
    bp = 1'b1;
    send_txn(1, 7, 12, 32'h6000_0000);
    send_txn(2, 7, 5, 32'h6100_0000);
    send_txn(3, 2, 0, 32'h6200_0000);
    drain();
    bp = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_whole_beats();
    t_partial();
    t_saturate();
    t_id_carry();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule